// File: doc/BRIEF.md
# Byte FIFO pair with threshold interrupt register set

This block sits between a serial bus engine and the software-facing register file of a two-wire bus controller. It holds two byte-wide queues: a transmit queue that software fills and the engine drains, and a receive queue that the engine fills and software drains. Each queue reports empty, full and a programmable threshold condition. The engine can also report transaction outcomes through single-cycle event pulses. All of these conditions are gathered into one 32-bit interrupt status word.

That word is filtered by a mask register and ORed into a single interrupt line. Occupancy conditions follow the queues from cycle to cycle. Event conditions stay set until software writes a one to the matching bit of the clear port. Each queue has its own flush request. A flush empties the queue at once and then holds a busy flag for a fixed number of cycles before the flag clears itself. While a flush is busy, software writes to the transmit port or reads from the receive port, whichever matches the flushing queue, are dropped.

Each flush is sequenced by a small controller with two states. FL_IDLE moves to FL_BUSY when a request arrives, and the queue is emptied on that same edge. FL_BUSY stays in FL_BUSY while its cycle counter is non-zero. It returns to FL_IDLE when the counter reaches zero. A request that arrives in FL_BUSY has no effect.

Top module: `dual_fifo_irq`

## Requirements
- R1: After reset the status word reads 0x13 (bits 0, 1, 4), the mask reads 0, the transmit threshold reads 0, the receive threshold reads 1, both flush flags read 0, the interrupt line is low, eng_tx_valid is low and eng_rx_ready is high.
- R2: Bytes accepted on the transmit write port leave on the engine side in the same order. eng_tx_valid is high whenever the transmit queue is not empty, and a byte is taken on each cycle where eng_tx_valid and eng_tx_ready are both high.
- R3: Bytes pushed by the engine are read by software in the same order. rx_rd_data shows the oldest byte, and eng_rx_ready is low while the receive queue is full, so that a push at that time is dropped.
- R4: The status bits follow occupancy: bit 0 transmit empty, bit 2 transmit full, bit 4 receive empty, bit 6 receive full (DEPTH entries).
- R5: Status bit 1 is set while the transmit queue holds no more entries than the transmit threshold. Status bit 5 is set while the receive queue holds at least the receive threshold number of entries.
- R6: The two 4-bit thresholds are written together. A value above DEPTH/2-1 is stored as DEPTH/2-1, which is 7 for the default depth of 16.
- R7: A software write while the transmit queue is full, and no transmit flush is busy, sets status bit 3. The byte is dropped.
- R8: Engine event pulses set sticky status bits: done at bit 19, arbitration lost at bit 24, bus error at bit 25 and done-without-stop at bit 28.
- R9: A write to the clear port clears the event bits where the written value holds a one, within the set 0x131f007f. Occupancy bits are not affected. An event arriving in the same cycle as its clear leaves the bit set.
- R10: The mask register ignores its top three bits and reads them as 0. masked_stat equals status AND mask, and irq is high exactly when masked_stat is non-zero.
- R11: A flush request accepted in FL_IDLE empties its queue on the same edge and raises its busy flag for exactly FLUSH_CYCLES cycles (4 by default). A request made while busy does not extend the flag.
- R12: While a transmit flush is busy, software writes are dropped. While a receive flush is busy, software reads are dropped. Engine pushes into the receive queue are still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_wr_en | input | 1 | Software write strobe for the transmit queue |
| tx_wr_data | input | 8 | Byte to enqueue |
| rx_rd_en | input | 1 | Software read strobe for the receive queue |
| rx_rd_data | output | 8 | Oldest byte in the receive queue |
| thr_wr_en | input | 1 | Write strobe for both thresholds |
| tx_thr_in | input | 4 | New transmit threshold |
| rx_thr_in | input | 4 | New receive threshold |
| tx_thr | output | 4 | Stored transmit threshold |
| rx_thr | output | 4 | Stored receive threshold |
| flush_tx_req | input | 1 | Start a transmit flush |
| flush_rx_req | input | 1 | Start a receive flush |
| flush_tx_busy | output | 1 | Transmit flush in progress |
| flush_rx_busy | output | 1 | Receive flush in progress |
| mask_wr_en | input | 1 | Mask register write strobe |
| mask_wr_data | input | 32 | Mask value |
| mask_q | output | 32 | Stored mask |
| clr_wr_en | input | 1 | Clear port write strobe |
| clr_wr_data | input | 32 | Bits to clear (write one to clear) |
| raw_stat | output | 32 | Unmasked status word |
| masked_stat | output | 32 | Status ANDed with mask |
| irq | output | 1 | Interrupt line |
| eng_tx_valid | output | 1 | Transmit byte available to engine |
| eng_tx_data | output | 8 | Transmit byte to engine |
| eng_tx_ready | input | 1 | Engine takes the transmit byte |
| eng_rx_valid | input | 1 | Engine offers a receive byte |
| eng_rx_data | input | 8 | Receive byte from engine |
| eng_rx_ready | output | 1 | Receive queue can accept |
| ev_done | input | 1 | Transaction done pulse |
| ev_done_nostop | input | 1 | Transaction done without stop pulse |
| ev_arb_lost | input | 1 | Arbitration lost pulse |
| ev_bus_err | input | 1 | Bus error pulse |

## Verification
Two operations can meet in a single cycle, and each pairing has a rule that decides the outcome. The first pairing is an engine event pulse and a software clear of the same bit. The bench drives a bus error pulse and a clear of every clearable bit on the same clock edge. It then expects bit 25 to stay set while bits 19 and 28, which received no new pulse, drop. The second pairing is a flush and traffic on either side of the same queue. The bench drives a software write during a transmit flush, then an engine push and a software read during a receive flush. It expects the transmit queue to stay empty, and it expects the pushed byte to remain readable once the busy flag falls.

// File: rtl/fq_pkg.sv
package fq_pkg;
    localparam int IRQ_W = 32;
    localparam logic [IRQ_W-1:0] CLR_ALLOWED = 32'h131f_007f;
    localparam logic [IRQ_W-1:0] MASK_ALLOWED = 32'h1fff_ffff;

    localparam int B_TX_EMPTY   = 0;
    localparam int B_TX_NEAR    = 1;
    localparam int B_TX_FULL    = 2;
    localparam int B_TX_OVR     = 3;
    localparam int B_RX_EMPTY   = 4;
    localparam int B_RX_NEAR    = 5;
    localparam int B_RX_FULL    = 6;
    localparam int B_DONE       = 19;
    localparam int B_ARB        = 24;
    localparam int B_BERR       = 25;
    localparam int B_DONE_NS    = 28;

    typedef enum logic [0:0] {
        FL_IDLE = 1'b0,
        FL_BUSY = 1'b1
    } flush_state_e;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic do_push, do_pop;

    assign do_push = push && (count != CW'(DEPTH));
    assign do_pop  = pop && (count != '0);
    assign head    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr] <= push_data;
    end
endmodule

// File: rtl/flush_ctrl.sv
module flush_ctrl
    import fq_pkg::*;
#(
    parameter int CYCLES = 4,
    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic clear,
    output logic busy
);
    flush_state_e state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FL_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            FL_IDLE: begin
                if (req) begin
                    state_nx = FL_BUSY;
                    cnt_nx   = CNT_W'(CYCLES - 1);
                end
            end
            FL_BUSY: begin
                if (cnt == '0) state_nx = FL_IDLE;
                else           cnt_nx   = cnt - 1'b1;
            end
        endcase
    end

    always_comb begin
        clear = (state == FL_IDLE) && req;
        busy  = (state == FL_BUSY);
    end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import fq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] level_bits,
    input  logic [IRQ_W-1:0] event_set,
    input  logic             mask_we,
    input  logic [IRQ_W-1:0] mask_wd,
    input  logic             clr_we,
    input  logic [IRQ_W-1:0] clr_wd,
    output logic [IRQ_W-1:0] raw,
    output logic [IRQ_W-1:0] masked,
    output logic [IRQ_W-1:0] mask_r,
    output logic             irq_o
);
    logic [IRQ_W-1:0] sticky, clr_eff;

    assign clr_eff = clr_we ? (clr_wd & CLR_ALLOWED) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sticky <= '0;
            mask_r <= '0;
        end else begin
            sticky <= (sticky & ~clr_eff) | (event_set & CLR_ALLOWED);
            if (mask_we) mask_r <= mask_wd & MASK_ALLOWED;
        end
    end

    assign raw    = (level_bits & CLR_ALLOWED) | sticky;
    assign masked = raw & mask_r;
    assign irq_o  = |masked;
endmodule

// File: rtl/dual_fifo_irq.sv
module dual_fifo_irq
    import fq_pkg::*;
#(
    parameter int DEPTH        = 16,
    parameter int THR_W        = 4,
    parameter int FLUSH_CYCLES = 4,
    localparam int CW          = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_wr_en,
    input  logic [7:0]       tx_wr_data,
    input  logic             rx_rd_en,
    output logic [7:0]       rx_rd_data,
    input  logic             thr_wr_en,
    input  logic [THR_W-1:0] tx_thr_in,
    input  logic [THR_W-1:0] rx_thr_in,
    output logic [THR_W-1:0] tx_thr,
    output logic [THR_W-1:0] rx_thr,
    input  logic             flush_tx_req,
    input  logic             flush_rx_req,
    output logic             flush_tx_busy,
    output logic             flush_rx_busy,
    input  logic             mask_wr_en,
    input  logic [31:0]      mask_wr_data,
    output logic [31:0]      mask_q,
    input  logic             clr_wr_en,
    input  logic [31:0]      clr_wr_data,
    output logic [31:0]      raw_stat,
    output logic [31:0]      masked_stat,
    output logic             irq,
    output logic             eng_tx_valid,
    output logic [7:0]       eng_tx_data,
    input  logic             eng_tx_ready,
    input  logic             eng_rx_valid,
    input  logic [7:0]       eng_rx_data,
    output logic             eng_rx_ready,
    input  logic             ev_done,
    input  logic             ev_done_nostop,
    input  logic             ev_arb_lost,
    input  logic             ev_bus_err
);
    localparam logic [THR_W-1:0] THR_MAX = THR_W'(DEPTH / 2 - 1);

    logic [CW-1:0] tx_cnt, rx_cnt;
    logic tx_clear, rx_clear;
    logic tx_empty, tx_full, rx_empty, rx_full;
    logic [IRQ_W-1:0] lvl, evs;

    function automatic logic [THR_W-1:0] clamp_thr(input logic [THR_W-1:0] v);
        return (v > THR_MAX) ? THR_MAX : v;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_thr <= '0;
            rx_thr <= THR_W'(1);
        end else if (thr_wr_en) begin
            tx_thr <= clamp_thr(tx_thr_in);
            rx_thr <= clamp_thr(rx_thr_in);
        end
    end

    flush_ctrl #(.CYCLES(FLUSH_CYCLES)) u_fl_tx (
        .clk(clk), .rst_n(rst_n), .req(flush_tx_req),
        .clear(tx_clear), .busy(flush_tx_busy)
    );

    flush_ctrl #(.CYCLES(FLUSH_CYCLES)) u_fl_rx (
        .clk(clk), .rst_n(rst_n), .req(flush_rx_req),
        .clear(rx_clear), .busy(flush_rx_busy)
    );

    byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_clear),
        .push(tx_wr_en && !flush_tx_busy), .push_data(tx_wr_data),
        .pop(eng_tx_ready), .head(eng_tx_data), .count(tx_cnt)
    );

    byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_clear),
        .push(eng_rx_valid), .push_data(eng_rx_data),
        .pop(rx_rd_en && !flush_rx_busy), .head(rx_rd_data), .count(rx_cnt)
    );

    assign tx_empty     = (tx_cnt == '0);
    assign tx_full      = (tx_cnt == CW'(DEPTH));
    assign rx_empty     = (rx_cnt == '0);
    assign rx_full      = (rx_cnt == CW'(DEPTH));
    assign eng_tx_valid = !tx_empty;
    assign eng_rx_ready = !rx_full;

    always_comb begin
        lvl = '0;
        lvl[B_TX_EMPTY] = tx_empty;
        lvl[B_TX_NEAR]  = 32'(tx_cnt) <= 32'(tx_thr);
        lvl[B_TX_FULL]  = tx_full;
        lvl[B_RX_EMPTY] = rx_empty;
        lvl[B_RX_NEAR]  = 32'(rx_cnt) >= 32'(rx_thr);
        lvl[B_RX_FULL]  = rx_full;
        evs = '0;
        evs[B_TX_OVR]   = tx_wr_en && !flush_tx_busy && tx_full;
        evs[B_DONE]     = ev_done;
        evs[B_ARB]      = ev_arb_lost;
        evs[B_BERR]     = ev_bus_err;
        evs[B_DONE_NS]  = ev_done_nostop;
    end

    irq_regs u_irq (
        .clk(clk), .rst_n(rst_n), .level_bits(lvl), .event_set(evs),
        .mask_we(mask_wr_en), .mask_wd(mask_wr_data),
        .clr_we(clr_wr_en), .clr_wd(clr_wr_data),
        .raw(raw_stat), .masked(masked_stat), .mask_r(mask_q), .irq_o(irq)
    );
endmodule

// File: rtl/fq_chk.sv
module fq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tx_wr_en,
    input logic        flush_tx_busy,
    input logic        flush_rx_busy,
    input logic [31:0] mask_q,
    input logic        clr_wr_en,
    input logic [31:0] clr_wr_data,
    input logic [31:0] raw_stat,
    input logic        eng_rx_ready,
    input logic        ev_bus_err
);
    p_mask_resv_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q[31:29] == 3'b000);

    p_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr_en && raw_stat[2] && !flush_tx_busy) |=> raw_stat[3]);

    p_berr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_bus_err |=> raw_stat[25]);

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_stat[25] && !(clr_wr_en && clr_wr_data[25])) |=> raw_stat[25]);

    p_full_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        raw_stat[6] |-> !eng_rx_ready);

    p_tx_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        flush_tx_busy |-> raw_stat[0]);

    p_flush_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_rx_busy) |=> flush_rx_busy);
endmodule

bind dual_fifo_irq fq_chk u_chk (.*);

// File: tb/sim_dual_fifo_irq.sv
module sim_dual_fifo_irq;
    logic clk = 1'b0, rst_n = 1'b0;
    logic tx_wr_en = 0, rx_rd_en = 0, thr_wr_en = 0;
    logic [7:0] tx_wr_data = 0, rx_rd_data, eng_tx_data, eng_rx_data = 0;
    logic [3:0] tx_thr_in = 0, rx_thr_in = 0, tx_thr, rx_thr;
    logic flush_tx_req = 0, flush_rx_req = 0, flush_tx_busy, flush_rx_busy;
    logic mask_wr_en = 0, clr_wr_en = 0, irq;
    logic [31:0] mask_wr_data = 0, clr_wr_data = 0, mask_q, raw_stat, masked_stat;
    logic eng_tx_valid, eng_tx_ready = 0, eng_rx_valid = 0, eng_rx_ready;
    logic ev_done = 0, ev_done_nostop = 0, ev_arb_lost = 0, ev_bus_err = 0;

    dual_fifo_irq u0 (.*);

    always #5 clk = ~clk;

    int errs = 0, checks = 0, tx_popped = 0;
    logic [7:0] tx_q[$], rx_q[$];
    bit done_flag = 0;

    task automatic expect_eq(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    // monitor: engine side of the transmit queue, sampled 1 ns before the edge
    initial forever begin
        @(negedge clk); #4;
        if (rst_n && eng_tx_valid && eng_tx_ready) begin
            tx_popped++;
            if (tx_q.size() == 0) expect_eq("R2 unexpected tx byte", {24'd0, eng_tx_data}, 32'hxx);
            else expect_eq("R2 tx order", {24'd0, eng_tx_data}, {24'd0, tx_q.pop_front()});
        end
    end

    initial begin
        #2000000;
        errs++; checks++;
        $display("FAIL watchdog R1 act=%0h exp=%0h", 0, 1);
        report();
    end

    task automatic sw_write(logic [7:0] b);
        @(negedge clk);
        tx_wr_en = 1; tx_wr_data = b;
        if (!raw_stat[2] && !flush_tx_busy) tx_q.push_back(b);
        @(negedge clk); tx_wr_en = 0;
    endtask

    task automatic eng_push(logic [7:0] b);
        @(negedge clk);
        eng_rx_valid = 1; eng_rx_data = b;
        if (eng_rx_ready) rx_q.push_back(b);
        @(negedge clk); eng_rx_valid = 0;
    endtask

    task automatic sw_read();
        @(negedge clk);
        expect_eq("R3 rx order", {24'd0, rx_rd_data}, {24'd0, rx_q.pop_front()});
        rx_rd_en = 1;
        @(negedge clk); rx_rd_en = 0;
    endtask

    task automatic set_thr(logic [3:0] t, logic [3:0] r);
        @(negedge clk); thr_wr_en = 1; tx_thr_in = t; rx_thr_in = r;
        @(negedge clk); thr_wr_en = 0;
    endtask

    task automatic set_mask(logic [31:0] m);
        @(negedge clk); mask_wr_en = 1; mask_wr_data = m;
        @(negedge clk); mask_wr_en = 0;
    endtask

    task automatic do_clear(logic [31:0] m);
        @(negedge clk); clr_wr_en = 1; clr_wr_data = m;
        @(negedge clk); clr_wr_en = 0;
    endtask

    task automatic drain_tx();
        @(negedge clk); eng_tx_ready = 1;
        for (int i = 0; i < 100 && !raw_stat[0]; i++) @(negedge clk);
        eng_tx_ready = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        expect_eq("R1 raw reset", raw_stat, 32'h13);
        expect_eq("R1 mask reset", mask_q, 0);
        expect_eq("R1 thr reset", {24'd0, tx_thr, rx_thr}, 32'h01);
        expect_eq("R1 flags reset", {irq, flush_tx_busy, flush_rx_busy, eng_tx_valid, eng_rx_ready}, 32'h1);

        set_thr(4'd12, 4'd9);
        expect_eq("R6 clamp", {24'd0, tx_thr, rx_thr}, 32'h77);
        set_thr(4'd2, 4'd3);
        expect_eq("R6 store", {24'd0, tx_thr, rx_thr}, 32'h23);

        sw_write(8'h11); sw_write(8'h22);
        expect_eq("R5 tx near at 2", raw_stat[1], 1);
        expect_eq("R4 tx not empty", {raw_stat[0], eng_tx_valid}, 32'h1);
        sw_write(8'h33);
        expect_eq("R5 tx near at 3", raw_stat[1], 0);
        eng_push(8'hA1); eng_push(8'hA2);
        expect_eq("R5 rx near at 2", {raw_stat[5], raw_stat[4]}, 0);
        eng_push(8'hA3);
        expect_eq("R5 rx near at 3", raw_stat[5], 1);

        drain_tx();
        expect_eq("R2 popped three", tx_popped, 3);
        expect_eq("R4 tx empty", raw_stat[0], 1);
        for (int i = 0; i < 3; i++) sw_read();
        expect_eq("R4 rx empty", raw_stat[4], 1);

        for (int i = 0; i < 16; i++) sw_write(8'(8'h40 + i));
        expect_eq("R4 tx full", raw_stat[2], 1);
        expect_eq("R7 no overrun yet", raw_stat[3], 0);
        sw_write(8'hEE);
        expect_eq("R7 overrun set", raw_stat[3], 1);
        drain_tx();
        expect_eq("R7 extra byte dropped", tx_popped, 19);

        for (int i = 0; i < 16; i++) eng_push(8'(8'h80 + i));
        expect_eq("R4 rx full", raw_stat[6], 1);
        expect_eq("R3 ready low when full", eng_rx_ready, 0);
        eng_push(8'hFF);
        for (int i = 0; i < 16; i++) sw_read();
        expect_eq("R3 rx drained", raw_stat[4], 1);

        do_clear(32'hFFFF_FFFF);
        expect_eq("R9 clear keeps level bits", raw_stat, 32'h13);

        @(negedge clk); ev_done = 1; ev_arb_lost = 1; ev_bus_err = 1; ev_done_nostop = 1;
        @(negedge clk); ev_done = 0; ev_arb_lost = 0; ev_bus_err = 0; ev_done_nostop = 0;
        expect_eq("R8 events latched", raw_stat, 32'h1308_0013);
        repeat (3) @(negedge clk);
        expect_eq("R8 events sticky", raw_stat, 32'h1308_0013);
        do_clear(32'h0100_0000);
        expect_eq("R9 single clear", raw_stat, 32'h1208_0013);

        set_mask(32'hFFFF_FFFF);
        expect_eq("R10 mask reserved", mask_q, 32'h1FFF_FFFF);
        expect_eq("R10 masked all", masked_stat, 32'h1208_0013);
        expect_eq("R10 irq high", irq, 1);
        set_mask(32'h0100_0000);
        expect_eq("R10 masked none", masked_stat, 0);
        expect_eq("R10 irq low", irq, 0);

        @(negedge clk); clr_wr_en = 1; clr_wr_data = 32'hFFFF_FFFF; ev_bus_err = 1;
        @(negedge clk); clr_wr_en = 0; ev_bus_err = 0;
        expect_eq("R9 set wins over clear", raw_stat, 32'h0200_0013);
        do_clear(32'h0200_0000);
        expect_eq("R9 cleared", raw_stat, 32'h13);

        // transmit flush
        sw_write(8'h01); sw_write(8'h02); sw_write(8'h03);
        begin
            int busy_n = 0;
            @(negedge clk); flush_tx_req = 1;
            @(negedge clk); flush_tx_req = 0; tx_q.delete();
            expect_eq("R11 flush empties tx", raw_stat[0], 1);
            busy_n += int'(flush_tx_busy);
            tx_wr_en = 1; tx_wr_data = 8'h77;
            @(negedge clk); tx_wr_en = 0; flush_tx_req = 1;
            busy_n += int'(flush_tx_busy);
            @(negedge clk); flush_tx_req = 0;
            busy_n += int'(flush_tx_busy);
            @(negedge clk); busy_n += int'(flush_tx_busy);
            @(negedge clk); busy_n += int'(flush_tx_busy);
            expect_eq("R11 busy length", busy_n, 4);
            expect_eq("R12 write dropped in flush", {raw_stat[0], eng_tx_valid}, 32'h2);
        end
        sw_write(8'h42);
        drain_tx();
        expect_eq("R2 after flush", tx_popped, 20);

        // receive flush
        eng_push(8'h10); eng_push(8'h20);
        @(negedge clk); flush_rx_req = 1;
        @(negedge clk); flush_rx_req = 0; rx_q.delete();
        expect_eq("R11 rx busy", flush_rx_busy, 1);
        expect_eq("R11 flush empties rx", raw_stat[4], 1);
        eng_rx_valid = 1; eng_rx_data = 8'hA5; rx_q.push_back(8'hA5);
        @(negedge clk); eng_rx_valid = 0; rx_rd_en = 1;
        @(negedge clk); rx_rd_en = 0;
        for (int i = 0; i < 10 && flush_rx_busy; i++) @(negedge clk);
        expect_eq("R12 read dropped in flush", raw_stat[4], 0);
        sw_read();
        expect_eq("R12 rx empty after read", raw_stat[4], 1);

        repeat (2) @(negedge clk);
        report();
    end
endmodule